// File: doc/BRIEF.md
# Single-Slope PWM Generator with Buffered Compare

This block is a counter-based waveform generator. A W-bit counter advances by one on every clock in which the `tick` enable is high. The `tick` input comes from an external prescaler that divides by 1, 8, 64, 256 or 1024. The counter climbs from zero to a TOP limit and then restarts at zero, so one waveform period lasts TOP+1 ticks. The output frequency is therefore the clock divided by prescale×(TOP+1).

TOP is taken from one of two places: the active compare value of channel A, or a separate limit register. Each of the two channels, A and B, compares its active value with the counter. It drives a pin in one of four modes: off, toggle, non-inverted or inverted.

Compare writes go first into a shadow register. The shadow is copied into the active register only on the tick where the counter sits at TOP. Duty-cycle and period changes therefore never take effect part-way through a period.

Top module: `fast_pwm_gen`

## Requirements
- R1: On each clock with `tick` high, the counter advances by one, or goes to zero when it equals TOP. With `tick` low it holds. `at_top` is high for each clock in which the counter equals TOP.
- R2: `top_sel`=0 takes TOP from the active compare value of channel A. `top_sel`=1 takes TOP from the limit register, and a write to that register applies from the next clock.
- R3: Mode 2 (non-inverted) sets an internal level on the tick where the counter is at TOP. On any other tick whose count equals the channel's compare value, it clears the level. The pin follows the level.
- R4: Mode 3 (inverted) drives the complement of the mode-2 level.
- R5: A compare value of zero in mode 2 gives a pin that is high for exactly one tick in every TOP+1 ticks.
- R6: A compare value equal to TOP holds the pin constantly high in mode 2 and constantly low in mode 3.
- R7: Mode 1 on channel A with `top_sel`=0 inverts the pin on every tick where the count equals the compare value. This gives a 50% square wave of period 2×(TOP+1) ticks, and a pin that changes on every tick when the compare value is zero.
- R8: Mode 0 drives the pin low. Mode 1 also drives it low on channel B, and on channel A whenever `top_sel`=1.
- R9: A compare write lands in a shadow register. The shadow is copied into the active value only on the tick where the counter is at TOP. A write made in that same clock goes straight through to the active value.
- R10: Outputs are registered, so a mode change is seen one clock later. Synchronous reset clears the counter, all registers, the levels and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler |
| cmp_a_we | input | 1 | Write strobe for the channel A compare shadow |
| cmp_a_wdata | input | CNT_W | Channel A compare write data |
| cmp_b_we | input | 1 | Write strobe for the channel B compare shadow |
| cmp_b_wdata | input | CNT_W | Channel B compare write data |
| lim_we | input | 1 | Write strobe for the limit register |
| lim_wdata | input | CNT_W | Limit register write data |
| top_sel | input | 1 | TOP source: 0 = channel A compare, 1 = limit register |
| mode_a | input | 2 | Channel A mode: 0 off, 1 toggle, 2 non-inverted, 3 inverted |
| mode_b | input | 2 | Channel B mode, same encoding (toggle acts as off) |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| at_top | output | 1 | Counter equals TOP |

## Verification
Every result of the block appears one clock after the rising edge that samples its cause. This covers a tick, a mode change and a limit write. A compare write differs: it moves the pins only from the tick that wraps the counter out of TOP. The bench drives inputs and samples outputs on the falling edge. A behavioural model advances on each rising edge and is compared with all three outputs every cycle. Directed checks first align to the clock after `at_top`, where the counter is zero. They then count high samples and pin changes over whole periods, so the results do not depend on phase.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_NONINV = 2'd2,
    OM_INV    = 2'd3
  } out_mode_e;

  localparam int unsigned NUM_CH = 2;

  // Pin value selected by the output mode from the channel's next state.
  function automatic logic pin_value(input out_mode_e m, input logic lvl,
                                     input logic tog, input logic tog_ok);
    logic v;
    case (m)
      OM_OFF:    v = 1'b0;
      OM_TOGGLE: v = tog_ok & tog;
      OM_NONINV: v = lvl;
      OM_INV:    v = ~lvl;
      default:   v = 1'b0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         wrap
);

  localparam logic [W-1:0] ONE = W'(1);

  assign wrap = tick && (cnt_q == top_val);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/fpwm_cmp_buf.sv
module fpwm_cmp_buf #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] act_q,
  output logic [W-1:0] act_d
);

  logic [W-1:0] shadow_q;
  logic [W-1:0] shadow_d;

  // A write in the load cycle goes straight through to the active value.
  assign shadow_d = we ? wdata : shadow_q;
  assign act_d    = load ? shadow_d : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      shadow_q <= shadow_d;
      act_q    <= act_d;
    end
  end

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
  import fpwm_pkg::*;
#(
  parameter int unsigned W         = 16,
  parameter bit          TOGGLE_OK = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wrap,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cmp_act,
  input  logic [1:0]   mode,
  input  logic         tog_en,
  output logic         wave_q
);

  logic lvl_q, lvl_d;
  logic tog_q, tog_d;
  logic match;
  logic tog_allow;

  assign match = tick && (cnt_q == cmp_act);

  // Wrap has priority: with compare equal to TOP the level never drops.
  always_comb begin
    lvl_d = lvl_q;
    if (wrap)       lvl_d = 1'b1;
    else if (match) lvl_d = 1'b0;
  end

  assign tog_d     = match ? ~tog_q : tog_q;
  assign tog_allow = TOGGLE_OK & tog_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      tog_q  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      tog_q  <= tog_d;
      wave_q <= pin_value(out_mode_e'(mode), lvl_d, tog_d, tog_allow);
    end
  end

endmodule

// File: rtl/fast_pwm_gen.sv
module fast_pwm_gen
  import fpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmp_a_we,
  input  logic [CNT_W-1:0] cmp_a_wdata,
  input  logic             cmp_b_we,
  input  logic [CNT_W-1:0] cmp_b_wdata,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_wdata,
  input  logic             top_sel,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  output logic             wave_a,
  output logic             wave_b,
  output logic             at_top
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;
  logic [CNT_W-1:0] top_val;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] top_next;

  logic             ch_we    [NUM_CH];
  logic [CNT_W-1:0] ch_wdata [NUM_CH];
  logic [CNT_W-1:0] act_q    [NUM_CH];
  logic [CNT_W-1:0] act_d    [NUM_CH];
  logic [1:0]       ch_mode  [NUM_CH];
  logic             ch_wave  [NUM_CH];
  logic [CNT_W-1:0] act_a_q;

  assign ch_we[0]    = cmp_a_we;
  assign ch_we[1]    = cmp_b_we;
  assign ch_wdata[0] = cmp_a_wdata;
  assign ch_wdata[1] = cmp_b_wdata;
  assign ch_mode[0]  = mode_a;
  assign ch_mode[1]  = mode_b;
  assign act_a_q     = act_q[0];

  assign top_val  = top_sel ? lim_q : act_q[0];
  assign lim_d    = lim_we ? lim_wdata : lim_q;
  assign top_next = top_sel ? lim_d : act_d[0];

  fpwm_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .top_val (top_val),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d),
    .wrap    (wrap)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    fpwm_cmp_buf #(.W(CNT_W)) u_buf (
      .clk   (clk),
      .rst   (rst),
      .we    (ch_we[ch]),
      .wdata (ch_wdata[ch]),
      .load  (wrap),
      .act_q (act_q[ch]),
      .act_d (act_d[ch])
    );

    fpwm_channel #(.W(CNT_W), .TOGGLE_OK(ch == 0)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .wrap    (wrap),
      .cnt_q   (cnt_q),
      .cmp_act (act_q[ch]),
      .mode    (ch_mode[ch]),
      .tog_en  (~top_sel),
      .wave_q  (ch_wave[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q  <= '0;
      at_top <= 1'b0;
    end else begin
      lim_q  <= lim_d;
      at_top <= (cnt_d == top_next);
    end
  end

  assign wave_a = ch_wave[0];
  assign wave_b = ch_wave[1];

endmodule

// File: rtl/fpwm_chk.sv
module fpwm_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic [W-1:0] top_val,
  input logic [W-1:0] act_a,
  input logic [1:0]   mode_a,
  input logic [1:0]   mode_b,
  input logic         wave_a,
  input logic         wave_b
);

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt != top_val) |=> (cnt == $past(cnt) + W'(1)));

  assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == top_val) |=> (cnt == '0));

  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(tick && cnt == top_val) |=> $stable(act_a));

  assert_off_low_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_a == 2'd0) |=> !wave_a);

  assert_b_no_toggle_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_b == 2'd1 || mode_b == 2'd0) |=> !wave_b);

endmodule

bind fast_pwm_gen fpwm_chk #(.W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .cnt     (cnt_q),
  .top_val (top_val),
  .act_a   (act_a_q),
  .mode_a  (mode_a),
  .mode_b  (mode_b),
  .wave_a  (wave_a),
  .wave_b  (wave_b)
);

// File: tb/fast_pwm_gen_tb.sv
`timescale 1ns/1ps
module fast_pwm_gen_tb;

  localparam int W    = 16;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0;
  logic         cmp_a_we = 1'b0, cmp_b_we = 1'b0, lim_we = 1'b0;
  logic [W-1:0] cmp_a_wdata = '0, cmp_b_wdata = '0, lim_wdata = '0;
  logic         top_sel = 1'b0;
  logic [1:0]   mode_a = 2'd0, mode_b = 2'd0;
  logic         wave_a, wave_b, at_top;

  int checks = 0, errors = 0;
  string cur_req = "R10";
  int div = 1, kdiv = 0;
  int hi_a, hi_b, ch_a, tops;
  bit done = 0;

  always #2.5 clk = ~clk;

  fast_pwm_gen #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .cmp_a_we(cmp_a_we), .cmp_a_wdata(cmp_a_wdata),
    .cmp_b_we(cmp_b_we), .cmp_b_wdata(cmp_b_wdata),
    .lim_we(lim_we), .lim_wdata(lim_wdata),
    .top_sel(top_sel), .mode_a(mode_a), .mode_b(mode_b),
    .wave_a(wave_a), .wave_b(wave_b), .at_top(at_top)
  );

  // Behavioural reference, advanced on every rising edge
  int m_cnt, m_lim, sh_a, sh_b, ac_a, ac_b, m_top;
  bit lv_a, lv_b, tg, e_a, e_b, e_t, hit_a, hit_b, wr;

  function automatic bit pin(int m, bit l, bit t, bit tog_ok);
    case (m)
      0: return 1'b0;
      1: return tog_ok ? t : 1'b0;
      2: return l;
      default: return !l;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_lim = 0; sh_a = 0; sh_b = 0; ac_a = 0; ac_b = 0;
      lv_a = 0; lv_b = 0; tg = 0; e_a = 0; e_b = 0; e_t = 0;
    end else begin
      m_top = top_sel ? m_lim : ac_a;
      if (cmp_a_we) sh_a = int'(cmp_a_wdata);
      if (cmp_b_we) sh_b = int'(cmp_b_wdata);
      if (tick) begin
        wr = (m_cnt == m_top);
        hit_a = (m_cnt == ac_a);
        hit_b = (m_cnt == ac_b);
        if (wr) begin lv_a = 1; lv_b = 1; end
        else begin
          if (hit_a) lv_a = 0;
          if (hit_b) lv_b = 0;
        end
        if (hit_a) tg = !tg;
        if (wr) begin ac_a = sh_a; ac_b = sh_b; m_cnt = 0; end
        else m_cnt = (m_cnt + 1) & MASK;
      end
      if (lim_we) m_lim = int'(lim_wdata);
      e_a = pin(int'(mode_a), lv_a, tg, !top_sel);
      e_b = pin(int'(mode_b), lv_b, 1'b0, 1'b0);
      e_t = (m_cnt == (top_sel ? m_lim : ac_a));
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (wave_a !== e_a || wave_b !== e_b || at_top !== e_t) begin
        errors++;
        $display("FAIL %s model: a=%b b=%b top=%b expected a=%b b=%b top=%b",
                 cur_req, wave_a, wave_b, at_top, e_a, e_b, e_t);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    tick = ((kdiv % div) == 0);
    kdiv++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Leaves the counter at zero (tick every clock)
  task automatic sync_bottom();
    while (!at_top) step();
    step();
  endtask

  task automatic measure(input int n);
    bit prev;
    hi_a = 0; hi_b = 0; ch_a = 0; tops = 0;
    prev = wave_a;
    for (int i = 0; i < n; i++) begin
      step();
      hi_a += int'(wave_a);
      hi_b += int'(wave_b);
      tops += int'(at_top);
      if (wave_a != prev) ch_a++;
      prev = wave_a;
    end
  endtask

  task automatic wr_a(input int v);
    cmp_a_wdata = W'(v); cmp_a_we = 1'b1; step(); cmp_a_we = 1'b0;
  endtask

  task automatic wr_b(input int v);
    cmp_b_wdata = W'(v); cmp_b_we = 1'b1; step(); cmp_b_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset wave_a", int'(wave_a), 0);
    chk("R10 reset wave_b", int'(wave_b), 0);
    chk("R10 reset at_top", int'(at_top), 0);
    rst = 1'b0;

    // R3 / R6 / R1: TOP from compare A = 9, B = 6
    cur_req = "R3";
    wr_a(9); wr_b(6);
    mode_a = 2'd2; mode_b = 2'd2;
    run(30); sync_bottom(); measure(10);
    chk("R3 noninv high ticks", hi_b, 7);
    chk("R6 cmp=TOP noninv high", hi_a, 10);
    chk("R1 one TOP per period", tops, 1);

    cur_req = "R4";
    mode_b = 2'd3; step(); measure(10);
    chk("R4 inverted high ticks", hi_b, 3);

    cur_req = "R5";
    wr_b(0); run(25); mode_b = 2'd2; step(); measure(10);
    chk("R5 spike width", hi_b, 1);
    mode_b = 2'd3; step(); measure(10);
    chk("R4 inverted spike complement", hi_b, 9);

    cur_req = "R6";
    wr_b(9); run(25); mode_b = 2'd3; step(); measure(10);
    chk("R6 cmp=TOP inverted low", hi_b, 0);
    mode_b = 2'd2; step(); measure(10);
    chk("R6 cmp=TOP noninv high", hi_b, 10);

    cur_req = "R1";
    div = 3; kdiv = 0; run(30); measure(30);
    chk("R1 prescaled at_top cycles", tops, 3);
    div = 1; kdiv = 0;

    cur_req = "R9";
    sync_bottom(); step(); step();
    wr_b(1); measure(6);
    chk("R9 old compare kept mid-period", hi_b, 6);
    sync_bottom(); measure(10);
    chk("R9 new compare after wrap", hi_b, 2);

    cur_req = "R2";
    sync_bottom();
    lim_wdata = W'(19); lim_we = 1'b1; step(); lim_we = 1'b0;
    top_sel = 1'b1;
    run(45); measure(20);
    chk("R2 limit register period", tops, 1);
    chk("R2 channel A duty under limit", hi_a, 10);
    chk("R2 channel B duty under limit", hi_b, 2);

    cur_req = "R8";
    mode_a = 2'd1; step(); measure(20);
    chk("R8 toggle A off when limit selects TOP", hi_a, 0);
    mode_b = 2'd1; step(); measure(20);
    chk("R8 toggle B always off", hi_b, 0);
    mode_a = 2'd0; step(); measure(20);
    chk("R8 mode 0 low", hi_a, 0);

    cur_req = "R7";
    sync_bottom(); top_sel = 1'b0;
    wr_a(3); run(25);
    mode_a = 2'd1; step(); measure(8);
    chk("R7 toggle duty", hi_a, 4);
    chk("R7 toggle edges per 2 periods", ch_a, 2);
    wr_a(0); run(12); measure(8);
    chk("R7 cmp 0 toggles every tick", ch_a, 8);
    chk("R7 cmp 0 duty", hi_a, 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule